// File: doc/BRIEF.md
# Dual-Accumulator Multiply/ALU Datapath

This block is the arithmetic core of a fixed-point signal processor. It holds two 16-bit signed multiplier operands (x and y), a 32-bit signed product register (p) and two 36-bit accumulators (a0 and a1). Each accumulator has four guard bits above a 32-bit value. On each clock it can take one instruction and one operand load.

An instruction names a function code, a destination accumulator and a source accumulator. It can also ask for a new product. The destination is written from the old product, from y, or from a sum, difference or bitwise result that combines the source accumulator with the product or with y. Two compare/test codes update only the flags.

Operand values come in on a load port. The load port writes x, y, either half of an accumulator, or the 8-bit control register. The control register sets two things. First, whether loading an accumulator's upper half keeps or clears its lower half. Second, whether loading y also fills x, which turns the next multiply into a square. A combinational read port returns y or either 16-bit half of an accumulator.

Top module: `mac_alu_unit`

## Requirements
- R1: While rstN is low, and after it is released, x, y, p, both accumulators, the control register and the three flags are all zero.
- R2: A valid instruction with function code 1..9 writes accumulator instDst at the clock edge. The codes are: 1 = p, 2 = aS+p, 3 = aS-p, 4 = y, 5 = aS+y, 6 = aS-y, 7 = aS&y, 8 = aS|y, 9 = aS^y, where aS is accumulator instSrc. As an operand, p is sign-extended to 36 bits. As an operand, y sits in bits [31:16] with zeros below and its sign copied into bits [35:32].
- R3: Function code 10 (aS-y) and function code 11 (aS&y) update the flags and write no accumulator.
- R4: Codes 1..11 set the flags from the 36-bit result. flagN is result bit 35. flagZ means the result is zero. flagV is 36-bit signed overflow for codes 2, 3, 5, 6 and 10, and is 0 for the other codes. Codes 0 and 12..15, and cycles with no valid instruction, leave the flags unchanged.
- R5: A valid instruction with instMul set loads p with the signed product of x and y as they stood before the edge. A function that reads p in the same instruction uses the old p.
- R6: A load to an accumulator's upper half (ldTarget 2 for a0, 3 for a1, with ldLow=0) writes bits [31:16] and copies the data sign into bits [35:32]. The lower 16 bits are cleared when the matching keep bit is 0 and kept when it is 1. The keep bit is control bit 0 for a0 and control bit 1 for a1.
- R7: An accumulator load with ldLow=1 writes only bits [15:0] and leaves bits [35:16] unchanged.
- R8: ldTarget 0 writes x. ldTarget 1 writes y. When control bit 7 is set, ldTarget 1 writes x as well. When it is clear, x keeps its value.
- R9: When an instruction writes an accumulator on the same edge as a load to that same accumulator, the instruction result is stored.
- R10: rdData is combinational. rdSel 0 returns y. rdSel 1 returns a0 and rdSel 2 returns a1: bits [15:0] when rdLow=1, bits [31:16] when rdLow=0. rdSel 3 returns zero.
- R11: ldTarget 4 loads the control register from ldData[7:0]. Targets 5..7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| instValid | input | 1 | An instruction is present this cycle |
| instFunc | input | 4 | Function code |
| instDst | input | 1 | Destination accumulator select |
| instSrc | input | 1 | Source accumulator select |
| instMul | input | 1 | Also form p = x*y |
| ldValid | input | 1 | An operand load is present this cycle |
| ldTarget | input | 3 | Load target: 0 x, 1 y, 2 a0, 3 a1, 4 control |
| ldLow | input | 1 | Accumulator load writes the low half |
| ldData | input | 16 | Load value |
| rdSel | input | 2 | Read source: 0 y, 1 a0, 2 a1 |
| rdLow | input | 1 | Read the low half of an accumulator |
| rdData | output | 16 | Read value |
| xOut | output | 16 | x register |
| yOut | output | 16 | y register |
| pOut | output | 32 | Product register |
| acc0Out | output | 36 | Accumulator a0 |
| acc1Out | output | 36 | Accumulator a1 |
| ctrlOut | output | 8 | Control register |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |

## Verification
Every register is visible at the ports, so a wrong accumulator, product, operand or flag value shows on the falling edge after the edge that wrote it. A wrong keep bit or square bit in the control register shows at the next upper-half or y load, as a changed low half or a wrong x. A wrong operand alignment or a wrong choice of old versus new p shows in the destination accumulator one cycle after the instruction.

// File: rtl/macalu_pkg.sv
package macalu_pkg;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_P    = 4'd1,
    OP_ADDP = 4'd2,
    OP_SUBP = 4'd3,
    OP_Y    = 4'd4,
    OP_ADDY = 4'd5,
    OP_SUBY = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_TSUB = 4'd10,
    OP_TAND = 4'd11
  } aluOp_e;

  typedef enum logic [2:0] {
    LD_X    = 3'd0,
    LD_Y    = 3'd1,
    LD_A0   = 3'd2,
    LD_A1   = 3'd3,
    LD_CTRL = 3'd4
  } ldTarget_e;

  typedef struct packed {
    aluOp_e     op;
    logic       accWe;
    logic       accDst;
    logic       accSrc;
    logic       flagWe;
    logic       mulEn;
    logic       xWe;
    logic       yWe;
    logic [1:0] accLdWe;
    logic       accLdLow;
    logic [1:0] keepLow;
  } strobes_t;

endpackage

// File: rtl/macalu_ctrl.sv
module macalu_ctrl
  import macalu_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int SQ_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        instFunc,
  input  logic              instDst,
  input  logic              instSrc,
  input  logic              instMul,
  input  logic              ldValid,
  input  logic [2:0]        ldTarget,
  input  logic              ldLow,
  input  logic [CTRL_W-1:0] ldCtrlData,
  output strobes_t          strobes,
  output logic [CTRL_W-1:0] ctrlQ
);

  logic [CTRL_W-1:0] ctrlReg;
  logic              ctrlWe;
  aluOp_e            opDec;

  assign ctrlWe = ldValid && (ldTarget == LD_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (ctrlWe) ctrlReg <= ldCtrlData;
  end

  assign ctrlQ = ctrlReg;

  always_comb begin
    if (instValid && (instFunc <= 4'd11)) opDec = aluOp_e'(instFunc);
    else opDec = OP_NONE;
  end

  always_comb begin
    strobes          = '0;
    strobes.op       = opDec;
    strobes.accDst   = instDst;
    strobes.accSrc   = instSrc;
    strobes.flagWe   = (opDec != OP_NONE);
    strobes.accWe    = (opDec != OP_NONE) && (opDec != OP_TSUB) && (opDec != OP_TAND);
    strobes.mulEn    = instValid && instMul;
    strobes.yWe      = ldValid && (ldTarget == LD_Y);
    strobes.xWe      = ldValid && ((ldTarget == LD_X) || ((ldTarget == LD_Y) && ctrlReg[SQ_BIT]));
    strobes.accLdWe  = {ldValid && (ldTarget == LD_A1), ldValid && (ldTarget == LD_A0)};
    strobes.accLdLow = ldLow;
    strobes.keepLow  = ctrlReg[1:0];
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWe |=> $stable(ctrlQ)) else $error("control register changed without a load"); // R11

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && (instFunc == 4'd10 || instFunc == 4'd11)) |-> (strobes.flagWe && !strobes.accWe))
    else $error("flag-only code requested an accumulator write"); // R3

endmodule

// File: rtl/macalu_accreg.sv
module macalu_accreg #(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 4,
  localparam int ACC_W  = 2 * DATA_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aluWe,
  input  logic [ACC_W-1:0]  aluRes,
  input  logic              ldWe,
  input  logic              ldLow,
  input  logic              keepLow,
  input  logic [DATA_W-1:0] ldData,
  output logic [ACC_W-1:0]  accQ
);

  logic [ACC_W-1:0] accReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
    end else if (aluWe) begin
      accReg <= aluRes;
    end else if (ldWe) begin
      if (ldLow) begin
        accReg[DATA_W-1:0] <= ldData;
      end else begin
        accReg[ACC_W-1:DATA_W] <= {{GUARD_W{ldData[DATA_W-1]}}, ldData};
        if (!keepLow) accReg[DATA_W-1:0] <= '0;
      end
    end
  end

  assign accQ = accReg;

  AST_LOW_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (ldWe && !ldLow && !keepLow && !aluWe) |=> (accQ[DATA_W-1:0] == '0))
    else $error("low half not cleared"); // R6

  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (ldWe && !ldLow && keepLow && !aluWe) |=> $stable(accQ[DATA_W-1:0]))
    else $error("low half not kept"); // R6

  AST_GUARD_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (ldWe && !ldLow && !aluWe) |=> (accQ[ACC_W-1:2*DATA_W] == {GUARD_W{accQ[2*DATA_W-1]}}))
    else $error("guard bits not sign extended"); // R6

  AST_LOW_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (ldWe && ldLow && !aluWe) |=> $stable(accQ[ACC_W-1:DATA_W]))
    else $error("low load disturbed upper bits"); // R7

  AST_ALU_WINS: assert property (@(posedge clk) disable iff (!rstN)
    aluWe |=> (accQ == $past(aluRes)))
    else $error("instruction result not stored"); // R9

endmodule

// File: rtl/macalu_dpath.sv
module macalu_dpath
  import macalu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 4,
  localparam int PROD_W = 2 * DATA_W,
  localparam int ACC_W  = PROD_W + GUARD_W,
  localparam int NUM_ACC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] ldData,
  input  logic [1:0]        rdSel,
  input  logic              rdLow,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] xQ,
  output logic [DATA_W-1:0] yQ,
  output logic [PROD_W-1:0] pQ,
  output logic [ACC_W-1:0]  acc0Q,
  output logic [ACC_W-1:0]  acc1Q,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV
);

  logic signed [DATA_W-1:0] xReg;
  logic signed [DATA_W-1:0] yReg;
  logic signed [PROD_W-1:0] pReg;
  logic signed [PROD_W-1:0] prodNext;
  logic [ACC_W-1:0]         accQ [NUM_ACC];
  logic [ACC_W-1:0]         srcAcc;
  logic [ACC_W-1:0]         pExt;
  logic [ACC_W-1:0]         yExt;
  logic [ACC_W-1:0]         arithOpnd;
  logic [ACC_W-1:0]         sumRes;
  logic [ACC_W-1:0]         diffRes;
  logic                     sumOvf;
  logic                     diffOvf;
  logic [ACC_W-1:0]         aluRes;
  logic                     aluOvf;
  logic                     nReg, zReg, vReg;

  // operand registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg <= '0;
      yReg <= '0;
    end else begin
      if (strobes.xWe) xReg <= ldData;
      if (strobes.yWe) yReg <= ldData;
    end
  end

  assign prodNext = xReg * yReg;

  always_ff @(posedge clk) begin
    if (!rstN) pReg <= '0;
    else if (strobes.mulEn) pReg <= prodNext;
  end

  // operand alignment
  assign srcAcc    = accQ[strobes.accSrc];
  assign pExt      = {{GUARD_W{pReg[PROD_W-1]}}, pReg};
  assign yExt      = {{GUARD_W{yReg[DATA_W-1]}}, yReg, {DATA_W{1'b0}}};
  assign arithOpnd = (strobes.op == OP_ADDP || strobes.op == OP_SUBP) ? pExt : yExt;

  assign sumRes  = srcAcc + arithOpnd;
  assign diffRes = srcAcc - arithOpnd;
  assign sumOvf  = (srcAcc[ACC_W-1] == arithOpnd[ACC_W-1]) && (sumRes[ACC_W-1] != srcAcc[ACC_W-1]);
  assign diffOvf = (srcAcc[ACC_W-1] != arithOpnd[ACC_W-1]) && (diffRes[ACC_W-1] != srcAcc[ACC_W-1]);

  always_comb begin
    aluRes = '0;
    aluOvf = 1'b0;
    unique case (strobes.op)
      OP_P:                    aluRes = pExt;
      OP_Y:                    aluRes = yExt;
      OP_ADDP, OP_ADDY:        begin aluRes = sumRes;  aluOvf = sumOvf;  end
      OP_SUBP, OP_SUBY, OP_TSUB: begin aluRes = diffRes; aluOvf = diffOvf; end
      OP_AND, OP_TAND:         aluRes = srcAcc & yExt;
      OP_OR:                   aluRes = srcAcc | yExt;
      OP_XOR:                  aluRes = srcAcc ^ yExt;
      default:                 aluRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nReg <= 1'b0;
      zReg <= 1'b0;
      vReg <= 1'b0;
    end else if (strobes.flagWe) begin
      nReg <= aluRes[ACC_W-1];
      zReg <= (aluRes == '0);
      vReg <= aluOvf;
    end
  end

  // accumulators
  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    macalu_accreg #(
      .DATA_W (DATA_W),
      .GUARD_W(GUARD_W)
    ) u_acc (
      .clk    (clk),
      .rstN   (rstN),
      .aluWe  (strobes.accWe && (strobes.accDst == 1'(g))),
      .aluRes (aluRes),
      .ldWe   (strobes.accLdWe[g]),
      .ldLow  (strobes.accLdLow),
      .keepLow(strobes.keepLow[g]),
      .ldData (ldData),
      .accQ   (accQ[g])
    );
  end

  // read port
  always_comb begin
    unique case (rdSel)
      2'd0:    rdData = yReg;
      2'd1:    rdData = rdLow ? accQ[0][DATA_W-1:0] : accQ[0][PROD_W-1:DATA_W];
      2'd2:    rdData = rdLow ? accQ[1][DATA_W-1:0] : accQ[1][PROD_W-1:DATA_W];
      default: rdData = '0;
    endcase
  end

  assign xQ    = xReg;
  assign yQ    = yReg;
  assign pQ    = pReg;
  assign acc0Q = accQ[0];
  assign acc1Q = accQ[1];
  assign flagN = nReg;
  assign flagZ = zReg;
  assign flagV = vReg;

  AST_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.mulEn |=> (pQ == PROD_W'($signed($past(xQ)) * $signed($past(yQ)))))
    else $error("product mismatch"); // R5

  AST_SQUARE_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.yWe && strobes.xWe) |=> (xQ == yQ))
    else $error("square load did not fill both operands"); // R8

  AST_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.op == OP_TSUB || strobes.op == OP_TAND) && strobes.accLdWe == 2'b00)
      |=> ($stable(acc0Q) && $stable(acc1Q)))
    else $error("flag-only form changed an accumulator"); // R3

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.flagWe |=> ($stable(flagN) && $stable(flagZ) && $stable(flagV)))
    else $error("flags changed without a function"); // R4

endmodule

// File: rtl/mac_alu_unit.sv
module mac_alu_unit
  import macalu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 4,
  parameter int CTRL_W  = 8,
  localparam int PROD_W = 2 * DATA_W,
  localparam int ACC_W  = PROD_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        instFunc,
  input  logic              instDst,
  input  logic              instSrc,
  input  logic              instMul,
  input  logic              ldValid,
  input  logic [2:0]        ldTarget,
  input  logic              ldLow,
  input  logic [DATA_W-1:0] ldData,
  input  logic [1:0]        rdSel,
  input  logic              rdLow,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] xOut,
  output logic [DATA_W-1:0] yOut,
  output logic [PROD_W-1:0] pOut,
  output logic [ACC_W-1:0]  acc0Out,
  output logic [ACC_W-1:0]  acc1Out,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV
);

  strobes_t strobes;

  macalu_ctrl #(
    .CTRL_W(CTRL_W),
    .SQ_BIT(CTRL_W - 1)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instFunc  (instFunc),
    .instDst   (instDst),
    .instSrc   (instSrc),
    .instMul   (instMul),
    .ldValid   (ldValid),
    .ldTarget  (ldTarget),
    .ldLow     (ldLow),
    .ldCtrlData(ldData[CTRL_W-1:0]),
    .strobes   (strobes),
    .ctrlQ     (ctrlOut)
  );

  macalu_dpath #(
    .DATA_W (DATA_W),
    .GUARD_W(GUARD_W)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .ldData (ldData),
    .rdSel  (rdSel),
    .rdLow  (rdLow),
    .rdData (rdData),
    .xQ     (xOut),
    .yQ     (yOut),
    .pQ     (pOut),
    .acc0Q  (acc0Out),
    .acc1Q  (acc1Out),
    .flagN  (flagN),
    .flagZ  (flagZ),
    .flagV  (flagV)
  );

endmodule

// File: tb/test_mac_alu_unit.sv
`timescale 1ns/1ps
module test_mac_alu_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid, instDst, instSrc, instMul;
  logic [3:0]  instFunc;
  logic        ldValid, ldLow;
  logic [2:0]  ldTarget;
  logic [15:0] ldData;
  logic [1:0]  rdSel;
  logic        rdLow;
  logic [15:0] rdData, xOut, yOut;
  logic [31:0] pOut;
  logic [35:0] acc0Out, acc1Out;
  logic [7:0]  ctrlOut;
  logic        flagN, flagZ, flagV;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference state
  logic [15:0] mX, mY;
  logic [31:0] mP;
  logic [35:0] mA [2];
  logic [7:0]  mC;
  logic        mN, mZ, mV;

  always #2 clk = ~clk;

  mac_alu_unit i_mac_alu_unit (
    .clk(clk), .rstN(rstN),
    .instValid(instValid), .instFunc(instFunc), .instDst(instDst),
    .instSrc(instSrc), .instMul(instMul),
    .ldValid(ldValid), .ldTarget(ldTarget), .ldLow(ldLow), .ldData(ldData),
    .rdSel(rdSel), .rdLow(rdLow), .rdData(rdData),
    .xOut(xOut), .yOut(yOut), .pOut(pOut),
    .acc0Out(acc0Out), .acc1Out(acc1Out), .ctrlOut(ctrlOut),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // {overflow, result}
  function automatic logic [36:0] calc(input logic [3:0] f, input logic [35:0] s,
                                       input logic [31:0] pp, input logic [15:0] yy);
    logic [35:0] pe, ye, o, r;
    logic v;
    pe = {{4{pp[31]}}, pp};
    ye = {{4{yy[15]}}, yy, 16'h0000};
    o  = (f == 4'd2 || f == 4'd3) ? pe : ye;
    v  = 1'b0;
    r  = '0;
    case (f)
      4'd1: r = pe;
      4'd4: r = ye;
      4'd2, 4'd5: begin
        r = s + o;
        v = (s[35] == o[35]) && (r[35] != s[35]);
      end
      4'd3, 4'd6, 4'd10: begin
        r = s - o;
        v = (s[35] != o[35]) && (r[35] != s[35]);
      end
      4'd7, 4'd11: r = s & ye;
      4'd8: r = s | ye;
      4'd9: r = s ^ ye;
      default: r = '0;
    endcase
    return {v, r};
  endfunction

  function automatic logic [15:0] rdModel(input logic [1:0] sel, input logic low);
    case (sel)
      2'd0: return mY;
      2'd1: return low ? mA[0][15:0] : mA[0][31:16];
      2'd2: return low ? mA[1][15:0] : mA[1][31:16];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic modelEdge();
    logic [36:0] r;
    logic [31:0] nP;
    logic        accInst;
    logic [7:0]  oldC;
    r       = calc(instFunc, mA[instSrc], mP, mY);
    nP      = (instValid && instMul) ? 32'($signed(mX) * $signed(mY)) : mP;
    accInst = instValid && (instFunc >= 4'd1) && (instFunc <= 4'd9);
    oldC    = mC;
    if (ldValid) begin
      case (ldTarget)
        3'd0: mX = ldData;
        3'd1: begin mY = ldData; if (oldC[7]) mX = ldData; end
        3'd2, 3'd3: begin
          if (!(accInst && instDst == ldTarget[0])) begin
            if (ldLow) mA[ldTarget[0]][15:0] = ldData;
            else begin
              mA[ldTarget[0]][35:16] = {{4{ldData[15]}}, ldData};
              if (!oldC[ldTarget[0]]) mA[ldTarget[0]][15:0] = 16'h0000;
            end
          end
        end
        3'd4: mC = ldData[7:0];
        default: ;
      endcase
    end
    if (accInst) mA[instDst] = r[35:0];
    if (instValid && instFunc >= 4'd1 && instFunc <= 4'd11) begin
      mN = r[35];
      mZ = (r[35:0] == 36'd0);
      mV = r[36];
    end
    mP = nP;
  endtask

  task automatic compareAll();
    check("R2 acc0", 64'(acc0Out), 64'(mA[0]));
    check("R2 acc1", 64'(acc1Out), 64'(mA[1]));
    check("R5 product", 64'(pOut), 64'(mP));
    check("R8 x/y", {32'h0, xOut, yOut}, {32'h0, mX, mY});
    check("R4 flags", 64'({flagN, flagZ, flagV}), 64'({mN, mZ, mV}));
    check("R11 control", 64'(ctrlOut), 64'(mC));
    check("R10 read port", 64'(rdData), 64'(rdModel(rdSel, rdLow)));
  endtask

  task automatic idle();
    instValid = 0; instFunc = 0; instDst = 0; instSrc = 0; instMul = 0;
    ldValid = 0; ldTarget = 0; ldLow = 0; ldData = 0;
  endtask

  task automatic cycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
    idle();
  endtask

  task automatic doLoad(input logic [2:0] t, input logic low, input logic [15:0] d);
    ldValid = 1; ldTarget = t; ldLow = low; ldData = d;
    cycle();
  endtask

  task automatic doInst(input logic [3:0] f, input logic dst, input logic src, input logic mul);
    instValid = 1; instFunc = f; instDst = dst; instSrc = src; instMul = mul;
    cycle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 0; rdSel = 0; rdLow = 0;
    idle();
    mX = 0; mY = 0; mP = 0; mA[0] = 0; mA[1] = 0; mC = 0; mN = 0; mZ = 0; mV = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 reset state", {acc0Out[27:0], pOut, ctrlOut, flagN, flagZ, flagV, 1'b0},
          64'h0);
    check("R1 reset operands", {32'h0, xOut, yOut}, 64'h0);
    rstN = 1;
    cycle();
    check("R1 after release", 64'(acc1Out), 64'h0);

    // R6: upper load clears low half when keep bit is 0
    doLoad(3'd2, 1'b1, 16'h1234);
    check("R7 low load", 64'(acc0Out), 64'h0_0000_1234);
    doLoad(3'd2, 1'b0, 16'h8001);
    check("R6 clear low", 64'(acc0Out), 64'hF_8001_0000);
    // R6: keep bit for a0 set
    doLoad(3'd4, 1'b0, 16'h0001);
    doLoad(3'd2, 1'b1, 16'h5678);
    doLoad(3'd2, 1'b0, 16'h0002);
    check("R6 keep low", 64'(acc0Out), 64'h0_0002_5678);
    // a1 keep bit is still 0
    doLoad(3'd3, 1'b1, 16'hAAAA);
    doLoad(3'd3, 1'b0, 16'h0003);
    check("R6 a1 clear low", 64'(acc1Out), 64'h0_0003_0000);

    // R8 square mode
    doLoad(3'd0, 1'b0, 16'h0007);
    doLoad(3'd4, 1'b0, 16'h0080);
    doLoad(3'd1, 1'b0, 16'hFFFD);
    check("R8 square copy", 64'(xOut), 64'hFFFD);
    doInst(4'd0, 1'b0, 1'b0, 1'b1);
    check("R5 square", 64'(pOut), 64'd9);
    doLoad(3'd4, 1'b0, 16'h0000);
    doLoad(3'd1, 1'b0, 16'h0005);
    check("R8 no copy", 64'(xOut), 64'hFFFD);

    // R5 old p used while new product forms: p=9, x=-3, y=5
    doInst(4'd1, 1'b0, 1'b0, 1'b1);
    check("R5 old p used", 64'(acc0Out), 64'h0_0000_0009);
    check("R5 new p", 64'(pOut), 64'hFFFF_FFF1);

    // R3 flag-only subtract: a0=9, y=5<<16 -> negative result
    doInst(4'd10, 1'b0, 1'b0, 1'b0);
    check("R3 acc untouched", 64'(acc0Out), 64'h0_0000_0009);
    check("R3 flags set", 64'({flagN, flagZ, flagV}), 64'b100);

    // R9 instruction beats load on same accumulator
    instValid = 1; instFunc = 4'd4; instDst = 1'b1; instSrc = 1'b0;
    ldValid = 1; ldTarget = 3'd3; ldLow = 1'b0; ldData = 16'h7777;
    cycle();
    check("R9 inst wins", 64'(acc1Out), 64'h0_0005_0000);

    // R11 ignored targets
    doLoad(3'd6, 1'b0, 16'hFFFF);
    check("R11 ignored target", {ctrlOut, xOut, yOut}, {8'h00, 16'hFFFD, 16'h0005});

    // R4 overflow run: a0 near top, add y repeatedly
    doLoad(3'd2, 1'b0, 16'h7FFF);
    doLoad(3'd1, 1'b0, 16'h7FFF);
    for (int i = 0; i < 20; i++) doInst(4'd5, 1'b0, 1'b0, 1'b0);

    // R10 read port sweep
    for (int s = 0; s < 8; s++) begin
      rdSel = s[1:0]; rdLow = s[2];
      #0.1;
      check("R10 read sweep", 64'(rdData), 64'(rdModel(rdSel, rdLow)));
    end

    // random mix
    for (int n = 0; n < 3000; n++) begin
      instValid = ($urandom % 10) < 7;
      instFunc  = 4'($urandom % 16);
      instDst   = 1'($urandom);
      instSrc   = 1'($urandom);
      instMul   = 1'($urandom);
      ldValid   = 1'($urandom);
      ldTarget  = (($urandom % 12) == 0) ? 3'd4 : 3'($urandom % 8);
      ldLow     = 1'($urandom);
      ldData    = 16'($urandom);
      rdSel     = 2'($urandom);
      rdLow     = 1'($urandom);
      cycle();
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule